// File: doc/BRIEF.md
# Secondary Bus Clock and Reset Controller

This block sits on the primary clock of a two-bus bridge. It produces the clocks, the speed indication and the reset for the secondary bus. The secondary clocks are modelled as per-cycle enables on the primary clock. An enable that is high in a cycle means the secondary clock has a rising edge in that cycle. A steady high enable is a secondary clock at the primary rate. An enable that alternates high and low is the primary clock divided by two.

While the primary reset is asserted, the block samples three straps: the 66 MHz capability strap, the primary speed input and the secondary speed line. From them it picks the secondary clock rate. It also decides whether to pull the secondary speed line low. That choice is held until the next primary reset. A 33 MHz primary with a 66 MHz secondary is never produced.

A bus/power clock control strap lets the deepest power state (D3) stop every secondary clock at low level. The secondary reset combines the primary reset with a software reset bit, without passing through any clock. The capability strap is also reported as the 66 MHz capable bit of both status registers.

Top module: `sec_clk_rst_ctrl`

## Requirements
- R1: `stat_66_cap` equals `cap66_strap` at all times. It is bit 5 of both the primary and the secondary status register.
- R2: `sec_m66_pd` is 1 exactly when, at the last clock edge with `pri_rst_n` low, `cap66_strap` was 1 and `pri_m66_in` was 0.
- R3: With capability 1, primary speed 1 and secondary speed 1 sampled in reset, every enable is 1 in each running cycle (66/66).
- R4: With capability 1, primary speed 1 and secondary speed 0 sampled in reset, the enables follow a 1,0,1,0 pattern starting with 1 (divide by two, 66/33).
- R5: With capability 0, or with primary speed 0, sampled in reset, the enables are 1 in each running cycle (33/33). The rate never halves in this mode, whatever the secondary speed line shows.
- R6: When `clk_stop_strap` is 1 and `pwr_state` equals D3 (code 2'b11), all enables are 0 from the next clock edge.
- R7: When `clk_stop_strap` is 0, `pwr_state` = 2'b11 has no effect on the enables.
- R8: On the first edge after a clock stop ends, and on the first edge after primary reset is released, the enables stay 0 (low phase). The normal pattern starts on the edge after that.
- R9: `sec_rst_n` = `pri_rst_n` AND NOT `sw_sec_rst`, combinationally, with no clock involved.
- R10: Changes of the speed inputs or of the capability strap after reset release do not change the chosen rate or `sec_m66_pd`.
- R11: All ten enables carry the same value in every cycle.
- R12: While `pri_rst_n` is low, all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary bus clock |
| pri_rst_n | input | 1 | Primary reset, active low |
| pri_m66_in | input | 1 | Primary 66 MHz enable input |
| sec_m66_in | input | 1 | Secondary speed line as sensed |
| cap66_strap | input | 1 | 66 MHz capability strap |
| pwr_state | input | 2 | Device power state, 2'b11 = D3 |
| clk_stop_strap | input | 1 | Allows D3 to stop the secondary clocks |
| sw_sec_rst | input | 1 | Software secondary-reset bit |
| sec_clk_en | output | 10 | Secondary clock enables, one per output |
| sec_m66_pd | output | 1 | Open-drain pull-down for the secondary speed line |
| sec_rst_n | output | 1 | Secondary reset, active low |
| stat_66_cap | output | 1 | 66 MHz capable status bit |

## Verification
The enables are registered, so a change in power state, clock-stop strap or reset release shows one primary edge later. The bench drives inputs on the falling edge. It steps its model at the next rising edge and compares at the falling edge after that. The speed decision and `sec_m66_pd` are expected from the input values held at the last rising edge inside reset. Straps that move after release must leave them unchanged. `sec_rst_n` and `stat_66_cap` are combinational and are compared in the same half cycle as the stimulus.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

   // speed decision held from the last reset cycle
   typedef struct packed {
      logic pull_low;   // drive secondary speed line low
      logic half;       // secondary runs at half the primary rate
   } spd_cfg_t;

   function automatic spd_cfg_t decide_speed(input logic cap, input logic pri_fast,
                                             input logic sec_fast);
      spd_cfg_t c;
      c.pull_low = cap & ~pri_fast;
      c.half     = cap & pri_fast & ~sec_fast;
      return c;
   endfunction

endpackage

// File: rtl/sclk_speed_latch.sv
module sclk_speed_latch
   import sclk_pkg::*;
(
   input  logic     clk,
   input  logic     pri_rst_n,
   input  logic     pri_fast,
   input  logic     sec_fast,
   input  logic     cap,
   output spd_cfg_t cfg
);

   // sampled only while primary reset is low; frozen afterwards
   always_ff @(posedge clk) begin
      if (!pri_rst_n)
         cfg <= decide_speed(cap, pri_fast, sec_fast);
   end

   // R10
   mode_hold_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      1'b1 |=> $stable(cfg));

   // R2
   mode_excl_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      cfg.pull_low |-> !cfg.half);

endmodule

// File: rtl/sclk_gate.sv
module sclk_gate #(
   parameter int NUM_CLK = 10,
   parameter int PWR_W   = 2,
   parameter int D3_CODE = 3
) (
   input  logic               clk,
   input  logic               pri_rst_n,
   input  logic               half,
   input  logic [PWR_W-1:0]   pwr_state,
   input  logic               stop_strap,
   output logic [NUM_CLK-1:0] clk_en
);

   localparam logic [PWR_W-1:0] D3_VAL = PWR_W'(D3_CODE);

   generate
      if (NUM_CLK < 1 || D3_CODE >= (1 << PWR_W)) begin : g_bad_cfg
         $error("sclk_gate: illegal parameter set");
      end
   endgenerate

   logic stop_req;
   logic phase_q;
   logic resume_q;
   logic nxt_en;

   assign stop_req = stop_strap && (pwr_state == D3_VAL);

   always_comb begin
      if (stop_req || resume_q) nxt_en = 1'b0;
      else if (half)            nxt_en = ~phase_q;
      else                      nxt_en = 1'b1;
   end

   always_ff @(posedge clk or negedge pri_rst_n) begin
      if (!pri_rst_n) begin
         phase_q  <= 1'b0;
         resume_q <= 1'b1;
      end else if (stop_req) begin
         phase_q  <= 1'b0;
         resume_q <= 1'b1;
      end else if (resume_q) begin
         phase_q  <= 1'b0;
         resume_q <= 1'b0;
      end else begin
         phase_q  <= half ? ~phase_q : 1'b0;
      end
   end

   // one flop per output, as each would sit beside its own buffer
   for (genvar gi = 0; gi < NUM_CLK; gi++) begin : g_out
      always_ff @(posedge clk or negedge pri_rst_n) begin
         if (!pri_rst_n) clk_en[gi] <= 1'b0;
         else            clk_en[gi] <= nxt_en;
      end
   end

   // R6
   stop_low_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      stop_req |=> (clk_en == '0));

   // R8
   restart_low_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      $fell(stop_req) |=> (clk_en == '0));

   // R4
   half_alt_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      (half && clk_en[0] && !stop_req) |=> !clk_en[0]);

   // R11
   out_match_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      1'b1 |-> (clk_en == {NUM_CLK{clk_en[0]}}));

endmodule

// File: rtl/sclk_rst_comb.sv
module sclk_rst_comb (
   input  logic clk,
   input  logic pri_rst_n,
   input  logic sw_sec_rst,
   output logic sec_rst_n
);

   // no clock on this path
   assign sec_rst_n = pri_rst_n & ~sw_sec_rst;

   // R9
   sw_rst_chk: assert property (@(posedge clk) disable iff (!pri_rst_n)
      sw_sec_rst |-> !sec_rst_n);

endmodule

// File: rtl/sec_clk_rst_ctrl.sv
module sec_clk_rst_ctrl
   import sclk_pkg::*;
#(
   parameter int NUM_CLK = 10,
   parameter int PWR_W   = 2,
   parameter int D3_CODE = 3
) (
   input  logic               clk_pri,
   input  logic               pri_rst_n,
   input  logic               pri_m66_in,
   input  logic               sec_m66_in,
   input  logic               cap66_strap,
   input  logic [PWR_W-1:0]   pwr_state,
   input  logic               clk_stop_strap,
   input  logic               sw_sec_rst,
   output logic [NUM_CLK-1:0] sec_clk_en,
   output logic               sec_m66_pd,
   output logic               sec_rst_n,
   output logic               stat_66_cap
);

   spd_cfg_t cfg;

   sclk_speed_latch u_speed (
      .clk       (clk_pri),
      .pri_rst_n (pri_rst_n),
      .pri_fast  (pri_m66_in),
      .sec_fast  (sec_m66_in),
      .cap       (cap66_strap),
      .cfg       (cfg)
   );

   sclk_gate #(
      .NUM_CLK (NUM_CLK),
      .PWR_W   (PWR_W),
      .D3_CODE (D3_CODE)
   ) u_gate (
      .clk        (clk_pri),
      .pri_rst_n  (pri_rst_n),
      .half       (cfg.half),
      .pwr_state  (pwr_state),
      .stop_strap (clk_stop_strap),
      .clk_en     (sec_clk_en)
   );

   sclk_rst_comb u_rst (
      .clk        (clk_pri),
      .pri_rst_n  (pri_rst_n),
      .sw_sec_rst (sw_sec_rst),
      .sec_rst_n  (sec_rst_n)
   );

   assign sec_m66_pd  = cfg.pull_low;
   assign stat_66_cap = cap66_strap;

   // R5
   slow_full_chk: assert property (@(posedge clk_pri) disable iff (!pri_rst_n)
      (sec_m66_pd && sec_clk_en[0]) |=> (sec_clk_en[0] || (clk_stop_strap && pwr_state == PWR_W'(D3_CODE))
                                         || $past(clk_stop_strap && pwr_state == PWR_W'(D3_CODE))));

endmodule

// File: tb/sec_clk_rst_ctrl_tb.sv
module sec_clk_rst_ctrl_tb;

   localparam int N = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         pri_f, sec_f, cap, stop_s, sw_r;
   logic [1:0]   pwr;
   logic [N-1:0] en;
   logic         pd, srst_n, stat;

   int n_tests = 0;
   int n_fail  = 0;

   // model state
   logic m_en, m_phase, m_resume, m_pd, m_half;
   string m_tag;

   always #5 clk = ~clk;

   sec_clk_rst_ctrl u_dut (
      .clk_pri        (clk),
      .pri_rst_n      (rst_n),
      .pri_m66_in     (pri_f),
      .sec_m66_in     (sec_f),
      .cap66_strap    (cap),
      .pwr_state      (pwr),
      .clk_stop_strap (stop_s),
      .sw_sec_rst     (sw_r),
      .sec_clk_en     (en),
      .sec_m66_pd     (pd),
      .sec_rst_n      (srst_n),
      .stat_66_cap    (stat)
   );

   function automatic logic exp_rst(input logic r, input logic s);
      return r & ~s;
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      logic stop;
      stop = stop_s && (pwr == 2'b11);
      if (!rst_n) begin
         m_pd = cap & ~pri_f;
         m_half = cap & pri_f & ~sec_f;
         m_en = 0; m_phase = 0; m_resume = 1; m_tag = "R12";
      end else if (stop) begin
         m_en = 0; m_phase = 0; m_resume = 1; m_tag = "R6";
      end else if (m_resume) begin
         m_en = 0; m_phase = 0; m_resume = 0; m_tag = "R8";
      end else if (m_half) begin
         m_en = ~m_phase; m_phase = ~m_phase; m_tag = "R4";
      end else begin
         m_en = 1; m_phase = 0; m_tag = m_pd ? "R5" : "R3";
         if (!cap || !pri_f) m_tag = "R5";
         if (pwr == 2'b11) m_tag = "R7";
      end
   endtask

   task automatic check_now();
      chk(en == {N{m_en}}, {m_tag, " R11 clock enables"}, 32'(en), 32'({N{m_en}}));
      chk(pd == m_pd, "R2,R10 speed pull-down", 32'(pd), 32'(m_pd));
      chk(srst_n == exp_rst(rst_n, sw_r), "R9 secondary reset", 32'(srst_n), 32'(exp_rst(rst_n, sw_r)));
      chk(stat == cap, "R1 capability status", 32'(stat), 32'(cap));
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_now();
   endtask

   task automatic do_reset(input logic c, input logic p, input logic s);
      rst_n = 0; cap = c; pri_f = p; sec_f = s;
      // R12: enables low at once under reset
      #1;
      chk(en == '0, "R12 enables in reset", 32'(en), 32'h0);
      chk(srst_n == 1'b0, "R9 reset follows primary", 32'(srst_n), 32'h0);
      repeat (3) step();
      rst_n = 1;
   endtask

   task automatic run(input int cyc);
      for (int i = 0; i < cyc; i++) step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240613));
      rst_n = 0; pri_f = 0; sec_f = 0; cap = 0; stop_s = 0; sw_r = 0; pwr = 2'b00;
      m_en = 0; m_phase = 0; m_resume = 1; m_pd = 0; m_half = 0; m_tag = "R12";
      @(negedge clk);

      // R3 66/66
      do_reset(1, 1, 1); run(8);
      // R4 66/33, then R10: move straps after release
      do_reset(1, 1, 0); run(7);
      pri_f = 0; sec_f = 1; cap = 0; run(6);
      // R5 33/33 with pull-down, secondary line high
      do_reset(1, 0, 1); run(6);
      // R5 not capable
      do_reset(0, 1, 0); run(6);
      // R6 / R8 stop and restart in half mode
      do_reset(1, 1, 0); run(5);
      stop_s = 1; pwr = 2'b11; run(4);
      pwr = 2'b00; run(6);
      // R7 D3 with strap low
      stop_s = 0; pwr = 2'b11; run(6);
      // R9 software reset
      sw_r = 1; #1;
      chk(srst_n == 1'b0, "R9 software reset", 32'(srst_n), 32'h0);
      run(2); sw_r = 0; #1;
      chk(srst_n == 1'b1, "R9 software reset release", 32'(srst_n), 32'h1);
      run(2);

      // random episodes
      for (int e = 0; e < 40; e++) begin
         do_reset(1'($urandom), 1'($urandom), 1'($urandom));
         for (int k = 0; k < 50; k++) begin
            if ($urandom % 6 == 0) pwr = 2'($urandom);
            if ($urandom % 10 == 0) stop_s = 1'($urandom);
            if ($urandom % 8 == 0) sw_r = 1'($urandom);
            if ($urandom % 12 == 0) begin
               pri_f = 1'($urandom); sec_f = 1'($urandom); cap = 1'($urandom);
            end
            step();
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule